// File: doc/BRIEF.md
# SPI Control Register and Interrupt Request Unit

This block holds the control word of a serial peripheral interface and turns status events from the shift engine into interrupt request pulses. Software writes the control word through a simple one-cycle write port. The word holds the function enable, master/slave select, mode-fault detection enable and three interrupt enables. A second write target clears the sticky error flags. The shift engine reports five single-cycle events: mode fault, overrun, parity error, transmit buffer empty and receive buffer full.

Three request lines come out of the block: error, transmit-empty and receive-full. Each is a one-cycle pulse. The block also drives the output enables of the clock, data-out, data-in and slave-select pins, and a one-cycle soft-reset pulse that clears the transfer logic when the function is switched off. While a mode fault is flagged, software cannot switch the function on. Changing the function enable in either direction counts as a transmit-empty condition.

Top module: `spi_ctl_irq`

## Requirements
- R1: All registers and outputs are 0 after reset. A write with `wr_sel`=0 loads `wr_data` into `ctrl_q` on the next edge, using this layout: bit0 function enable, bit1 master select, bit2 mode-fault detection enable, bit3 error interrupt enable, bit4 transmit-empty interrupt enable, bit5 receive-full interrupt enable.
- R2: While `flags_q[0]` (mode fault) is 1, a control write cannot change the function enable from 0 to 1. The other bits of that write still load, and clearing the enable still works.
- R3: `irq_err` pulses for exactly the cycle after an edge at which the error interrupt enable was already 1 and an accepted mode fault, overrun or parity event was present.
- R4: `irq_txe` pulses for one cycle after any edge that changes the function enable, in either direction, when the transmit-empty interrupt enable is 1 after that edge. This covers the case where both bits are set by the same write.
- R5: `ev_tx_empty` also produces an `irq_txe` pulse on the next cycle when the transmit-empty interrupt enable is 1 after that edge. The function enable does not gate it, and a coincident toggle still gives a single pulse.
- R6: `irq_rxf` pulses for one cycle after an edge at which `ev_rx_full` was 1 and the receive-full interrupt enable was 1.
- R7: The master bit sets the pin directions: `sck_oe`=`mosi_oe`=master and `miso_oe`=not master. `ss_oe` is 1 only when master is 1 and mode-fault detection is 0.
- R8: `shift_rst` pulses for exactly the one cycle after the edge at which the function enable goes from 1 to 0.
- R9: The flags in `flags_q` (bit0 mode fault, bit1 overrun, bit2 parity) are sticky. A mode fault event counts only while detection is enabled. A write with `wr_sel`=1 clears each flag whose `wr_data` bit is 0 and leaves the flags whose bit is 1. An event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 flag clear |
| wr_data | input | 6 | Write data |
| ev_mode_fault | input | 1 | Mode fault event from the shift engine |
| ev_overrun | input | 1 | Overrun event |
| ev_parity | input | 1 | Parity error event |
| ev_tx_empty | input | 1 | Transmit buffer empty event |
| ev_rx_full | input | 1 | Receive buffer written after a transfer |
| ctrl_q | output | 6 | Current control word |
| flags_q | output | 3 | Sticky error flags |
| irq_err | output | 1 | Error interrupt request pulse |
| irq_txe | output | 1 | Transmit-empty interrupt request pulse |
| irq_rxf | output | 1 | Receive-full interrupt request pulse |
| sck_oe | output | 1 | Clock pin output enable |
| mosi_oe | output | 1 | Master data-out pin output enable |
| miso_oe | output | 1 | Master data-in pin output enable |
| ss_oe | output | 1 | Slave-select pins output enable |
| shift_rst | output | 1 | Soft-reset pulse to the transfer logic |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a transmit-empty event from the shifter and a control write that toggles the function enable. The second pair is an error event and a flag-clear write that targets the same flag. Random stimulus drives events and writes in the same cycle often. A short directed sequence also forces each collision. A bench model expects exactly one `irq_txe` pulse from the first pair and a flag that stays set after the second.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int CTRL_W = 6;
    localparam int ERR_N  = 3;

    // bit0 fn_en ... bit5 rxf_ie (layout decoded by software)
    typedef struct packed {
        logic rxf_ie;
        logic txe_ie;
        logic err_ie;
        logic mfd_en;
        logic master;
        logic fn_en;
    } ctrl_t;

    // bit0 mode fault, bit1 overrun, bit2 parity
    typedef struct packed {
        logic parity;
        logic overrun;
        logic modf;
    } err_t;

    typedef struct packed {
        logic sck_oe;
        logic mosi_oe;
        logic miso_oe;
        logic ss_oe;
    } pin_dir_t;

    function automatic pin_dir_t pick_dirs(input logic master, input logic mfd_en);
        pin_dir_t d;
        d.sck_oe  = master;
        d.mosi_oe = master;
        d.miso_oe = ~master;
        d.ss_oe   = master & ~mfd_en;
        return d;
    endfunction

    // A flagged mode fault blocks a 0->1 change of the enable only
    function automatic logic gate_enable(input logic req, input logic cur, input logic fault);
        return fault ? (cur & req) : req;
    endfunction

endpackage

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              modf_flag,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_d,
    output logic              fn_toggle,
    output logic              fn_fall
);

    ctrl_t req;

    always_comb begin
        req       = ctrl_t'(wr_data);
        ctrl_d    = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d       = req;
            ctrl_d.fn_en = gate_enable(req.fn_en, ctrl_q.fn_en, modf_flag);
        end
        fn_toggle = ctrl_d.fn_en ^ ctrl_q.fn_en;
        fn_fall   = ctrl_q.fn_en & ~ctrl_d.fn_en;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    a_r2_enable_locked: assert property (@(posedge clk) disable iff (rst)
        (modf_flag && !ctrl_q.fn_en) |=> !ctrl_q.fn_en);

endmodule

// File: rtl/spi_ctl_flags.sv
module spi_ctl_flags
    import spi_ctl_pkg::*;
#(
    parameter int N = ERR_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_clr,
    input  logic [N-1:0] keep_mask,
    input  logic [N-1:0] set_vec,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic clr;
        assign clr = wr_clr & ~keep_mask[i];

        always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr)        flags[i] <= 1'b0;
        end

        a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr) |=> flags[i]);
        a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> flags[i]);
    end

endmodule

// File: rtl/spi_ctl_irq_gen.sv
module spi_ctl_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic err_ie,
    input  logic rxf_ie,
    input  logic txe_ie_next,
    input  logic err_event,
    input  logic ev_tx_empty,
    input  logic ev_rx_full,
    input  logic fn_toggle,
    input  logic fn_fall,
    output logic irq_err,
    output logic irq_txe,
    output logic irq_rxf,
    output logic shift_rst
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_err   <= 1'b0;
            irq_txe   <= 1'b0;
            irq_rxf   <= 1'b0;
            shift_rst <= 1'b0;
        end else begin
            irq_err   <= err_ie & err_event;
            irq_txe   <= txe_ie_next & (ev_tx_empty | fn_toggle);
            irq_rxf   <= rxf_ie & ev_rx_full;
            shift_rst <= fn_fall;
        end
    end

    a_r3_err_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> $past(err_ie));
    a_r6_rxf_needs_event: assert property (@(posedge clk) disable iff (rst)
        irq_rxf |-> $past(ev_rx_full));

endmodule

// File: rtl/spi_ctl_irq.sv
module spi_ctl_irq
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              ev_mode_fault,
    input  logic              ev_overrun,
    input  logic              ev_parity,
    input  logic              ev_tx_empty,
    input  logic              ev_rx_full,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [ERR_N-1:0]  flags_q,
    output logic              irq_err,
    output logic              irq_txe,
    output logic              irq_rxf,
    output logic              sck_oe,
    output logic              mosi_oe,
    output logic              miso_oe,
    output logic              ss_oe,
    output logic              shift_rst
);

    ctrl_t    ctrl_cur;
    ctrl_t    ctrl_nxt;
    err_t     flag_s;
    err_t     set_s;
    pin_dir_t dirs;
    logic     fn_toggle;
    logic     fn_fall;
    logic     armed;

    spi_ctl_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_en & ~wr_sel),
        .wr_data   (wr_data),
        .modf_flag (flag_s.modf),
        .ctrl_q    (ctrl_cur),
        .ctrl_d    (ctrl_nxt),
        .fn_toggle (fn_toggle),
        .fn_fall   (fn_fall)
    );

    always_comb begin
        set_s.modf    = ev_mode_fault & ctrl_cur.mfd_en;
        set_s.overrun = ev_overrun;
        set_s.parity  = ev_parity;
    end

    spi_ctl_flags #(.N(ERR_N)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_clr    (wr_en & wr_sel),
        .keep_mask (wr_data[ERR_N-1:0]),
        .set_vec   (set_s),
        .flags     (flag_s)
    );

    spi_ctl_irq_gen u_irq (
        .clk         (clk),
        .rst         (rst),
        .err_ie      (ctrl_cur.err_ie),
        .rxf_ie      (ctrl_cur.rxf_ie),
        .txe_ie_next (ctrl_nxt.txe_ie),
        .err_event   (|set_s),
        .ev_tx_empty (ev_tx_empty),
        .ev_rx_full  (ev_rx_full),
        .fn_toggle   (fn_toggle),
        .fn_fall     (fn_fall),
        .irq_err     (irq_err),
        .irq_txe     (irq_txe),
        .irq_rxf     (irq_rxf),
        .shift_rst   (shift_rst)
    );

    assign dirs    = pick_dirs(ctrl_cur.master, ctrl_cur.mfd_en);
    assign sck_oe  = dirs.sck_oe;
    assign mosi_oe = dirs.mosi_oe;
    assign miso_oe = dirs.miso_oe;
    assign ss_oe   = dirs.ss_oe;
    assign ctrl_q  = ctrl_cur;
    assign flags_q = flag_s;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r4_toggle_raises_txe: assert property (@(posedge clk) disable iff (rst || !armed)
        ((ctrl_cur.fn_en != $past(ctrl_cur.fn_en)) && ctrl_cur.txe_ie) |-> irq_txe);
    a_r8_fall_resets: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(ctrl_cur.fn_en) |-> shift_rst);
    a_r8_reset_only_on_fall: assert property (@(posedge clk) disable iff (rst)
        shift_rst |-> !ctrl_cur.fn_en);
    a_r7_slave_select_dir: assert property (@(posedge clk) disable iff (rst)
        ss_oe |-> (sck_oe && !miso_oe && !ctrl_cur.mfd_en));

endmodule

// File: tb/spi_ctl_irq_test.sv
module spi_ctl_irq_test;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [5:0] wr_data = '0;
    logic       ev_mode_fault = 1'b0, ev_overrun = 1'b0, ev_parity = 1'b0;
    logic       ev_tx_empty = 1'b0, ev_rx_full = 1'b0;
    logic [5:0] ctrl_q;
    logic [2:0] flags_q;
    logic       irq_err, irq_txe, irq_rxf;
    logic       sck_oe, mosi_oe, miso_oe, ss_oe, shift_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [5:0] m_ctrl;
    logic [2:0] m_flags;
    logic       e_err, e_txe, e_rxf, e_srst;
    string      txe_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ctl_irq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ev_mode_fault(ev_mode_fault), .ev_overrun(ev_overrun), .ev_parity(ev_parity),
        .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full),
        .ctrl_q(ctrl_q), .flags_q(flags_q),
        .irq_err(irq_err), .irq_txe(irq_txe), .irq_rxf(irq_rxf),
        .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ss_oe(ss_oe),
        .shift_rst(shift_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_dirs(input logic [5:0] c);
        // {sck, mosi, miso, ss}
        return {c[1], c[1], ~c[1], c[1] & ~c[2]};
    endfunction

    task automatic compare_all();
        chk("R1 ctrl", int'(ctrl_q), int'(m_ctrl));
        chk("R9 flags", int'(flags_q), int'(m_flags));
        chk("R3 irq_err", int'(irq_err), int'(e_err));
        chk(txe_tag, int'(irq_txe), int'(e_txe));
        chk("R6 irq_rxf", int'(irq_rxf), int'(e_rxf));
        chk("R8 shift_rst", int'(shift_rst), int'(e_srst));
        chk("R7 pins", int'({sck_oe, mosi_oe, miso_oe, ss_oe}), int'(exp_dirs(m_ctrl)));
    endtask

    // ev: {rx_full, tx_empty, parity, overrun, mode_fault}
    task automatic model_step(input logic we, input logic sel, input logic [5:0] d,
                              input logic [4:0] ev);
        logic [5:0] nxt;
        logic       acc_mf, tog;
        logic [2:0] clr;
        nxt = m_ctrl;
        if (we && !sel) begin
            nxt = d;
            if (m_flags[0] && !m_ctrl[0]) nxt[0] = 1'b0;
        end
        acc_mf  = ev[0] & m_ctrl[2];
        tog     = nxt[0] ^ m_ctrl[0];
        e_err   = m_ctrl[3] & (acc_mf | ev[1] | ev[2]);
        e_txe   = nxt[4] & (ev[3] | tog);
        txe_tag = tog ? "R4 irq_txe" : "R5 irq_txe";
        e_rxf   = m_ctrl[5] & ev[4];
        e_srst  = m_ctrl[0] & ~nxt[0];
        clr     = (we && sel) ? ~d[2:0] : 3'b000;
        m_flags = (m_flags & ~clr) | {ev[2], ev[1], acc_mf};
        m_ctrl  = nxt;
    endtask

    task automatic cyc(input logic we, input logic sel, input logic [5:0] d,
                       input logic [4:0] ev);
        @(negedge clk);
        compare_all();
        wr_en = we; wr_sel = sel; wr_data = d;
        {ev_rx_full, ev_tx_empty, ev_parity, ev_overrun, ev_mode_fault} = ev;
        model_step(we, sel, d, ev);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_ctrl = '0; m_flags = '0;
        e_err = 0; e_txe = 0; e_rxf = 0; e_srst = 0; txe_tag = "R5 irq_txe";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cyc(0, 0, 6'h00, 5'b0);

        // R4: enable and txe_ie in the same write
        cyc(1, 0, 6'h11, 5'b0);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R4 same-write pulse", int'(irq_txe), 1);
        // R4/R8: disable with txe_ie kept
        cyc(1, 0, 6'h10, 5'b0);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R8 soft reset", int'(shift_rst), 1);
        // R5: tx empty with function off
        cyc(0, 0, 6'h00, 5'b01000);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R5 txe while off", int'(irq_txe), 1);
        // R4: later write sets enable after txe_ie already 1
        cyc(1, 0, 6'h11, 5'b01000);
        cyc(0, 0, 6'h00, 5'b0);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R4 single pulse after coincidence", int'(irq_txe), 0);

        // R2: mode fault lock
        cyc(1, 0, 6'h0C, 5'b0);
        cyc(0, 0, 6'h00, 5'b00001);
        cyc(1, 0, 6'h0D, 5'b0);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R2 enable locked", int'(ctrl_q[0]), 0);
        // R9: clear collides with a new event: event wins
        cyc(1, 1, 6'h06, 5'b00001);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R9 set wins", int'(flags_q[0]), 1);
        cyc(1, 1, 6'h06, 5'b0);
        cyc(1, 0, 6'h0D, 5'b0);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R2 enable after clear", int'(ctrl_q[0]), 1);
        // R7: master without detection
        cyc(1, 0, 6'h03, 5'b0);
        cyc(0, 0, 6'h00, 5'b0);
        chk("R7 ss out", int'(ss_oe), 1);
        // R6
        cyc(1, 0, 6'h20, 5'b10000);
        cyc(0, 0, 6'h00, 5'b10000);
        cyc(0, 0, 6'h00, 5'b0);

        void'($urandom(32'd2468));
        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic we, sel;
            logic [5:0] d;
            logic [4:0] ev;
            we  = ($urandom % 4) == 0;
            sel = $urandom % 3 == 0;
            d   = 6'($urandom);
            ev  = 5'($urandom) & 5'($urandom);
            cyc(we, sel, d, ev);
        end
        cyc(0, 0, 6'h00, 5'b0);
        cyc(0, 0, 6'h00, 5'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule